// File: doc/BRIEF.md
# Two-Wire Eight-Pin Port Expander

This block is a two-wire serial (I2C) target that gives a controller byte-wide access to eight general-purpose pins. A fast system clock oversamples the SCL and SDA lines. The block pulls SDA low through an open-drain enable. Its 7-bit bus address is `11100` in the upper five bits. The two lowest bits come from strap inputs, with `addr_strap[1]` above `addr_strap[0]`. After the address, a controller writes a command byte whose low two bits select one of four byte registers: pin levels (index 0), drive values (index 1), read inversion (index 2) and direction (index 3).

The block owns the per-pin drive value and drive enable. It samples the pin levels through a synchronizer. An open-drain interrupt request tells the controller that an input pin has moved away from the level it saw at its last read of the pin-level register. The register pointer keeps its value between transfers. A controller can therefore poll one register by issuing reads only.

The bus engine has these states: IDLE (bus free or transfer ignored), ADDR (shifting in the address byte), ADDR_ACK (acknowledging a matching address), CMD (shifting in the command byte), CMD_ACK, WDATA (shifting in a data byte), WDATA_ACK, RDATA (shifting out a data byte) and RACK (releasing SDA and sampling the controller's acknowledge).

Its transitions are:
- A START from any state goes to ADDR.
- A STOP from any state goes to IDLE.
- After eight address bits, ADDR goes to ADDR_ACK on a match and to IDLE otherwise.
- ADDR_ACK goes to RDATA for a read and to CMD for a write.
- CMD goes to CMD_ACK, and CMD_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RACK.
- RACK goes back to RDATA on an acknowledge and to IDLE on a not-acknowledge.

Top module: `gpx_top`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `1110 0`, then `addr_strap[1]`, then `addr_strap[0]`. Bit 0 of that byte is the direction, with 1 meaning read. Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R2: Only bits [1:0] of the command byte are decoded, as a pointer. Index 0 reads the pin levels, 1 the drive values, 2 the read-inversion mask and 3 the direction register. Indices 1 to 3 read back what was last written.
- R3: The pointer keeps its value across STOP and START. A read with no command byte returns the register selected last. Consecutive data bytes in one transfer, written or read, all access the same register.
- R4: `pin_out` equals the drive-value register. `pin_oe[i]` is high exactly when direction bit i is 0.
- R5: A read of index 0 returns the synchronized pin levels XOR the inversion mask, for every pin, whatever its direction.
- R6: A write to index 0 changes no register, no pin output and no drive enable.
- R7: While `rst_n` is low, the drive values become 0xFF, the inversion mask becomes 0x00 and the direction register becomes 0xFF (all pins undriven). The interrupt and SDA are released, and the bus engine returns to IDLE.
- R8: `irq_pull` rises when a pin whose direction bit is 1 differs from the level captured at the last read of index 0. Pins set as outputs never raise it.
- R9: `irq_pull` falls after the pin-level register is read, or after the pins return to the captured levels.
- R10: The block acknowledges every command and data byte written to it. After each byte it sends, it releases SDA for the controller's acknowledge. A not-acknowledge ends the read with SDA left released.
- R11: A START in any state restarts the address phase. A STOP in any state returns the engine to IDLE with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Level of the serial clock line |
| sda_in | input | 1 | Level of the serial data line |
| sda_oe | output | 1 | High to pull SDA low |
| addr_strap | input | 2 | Strapped low address bits |
| pin_in | input | 8 | Levels present on the eight pins |
| pin_out | output | 8 | Drive value for each pin |
| pin_oe | output | 8 | Drive enable for each pin |
| irq_pull | output | 1 | High to pull the interrupt line low |

## Verification
A bit counter or state that is off by one shows up on SDA within the same byte. The acknowledge then lands in the wrong bit slot, or a read byte comes back shifted, and the bench sees this at the next acknowledge or at the end of that byte. A wrong pointer or register update appears as a wrong `pin_out` or `pin_oe` a few system clocks after the written byte is acknowledged, or as a wrong byte on the next read. A stale interrupt capture shows as `irq_pull` that fails to rise or fall within a handful of system clocks after a pin change or a pin-level read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } gpx_state_e;

    localparam logic [PTR_W-1:0] IDX_LEVEL = 2'd0;
    localparam logic [PTR_W-1:0] IDX_DRIVE = 2'd1;
    localparam logic [PTR_W-1:0] IDX_INV   = 2'd2;
    localparam logic [PTR_W-1:0] IDX_DIR   = 2'd3;
endpackage

// File: rtl/gpx_line_sync.sv
module gpx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe[0] <= scl_in;
            sda_pipe[0] <= sda_in;
            for (int i = 1; i < STAGES; i++) begin
                scl_pipe[i] <= scl_pipe[i-1];
                sda_pipe[i] <= sda_pipe[i-1];
            end
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/gpx_bus_fsm.sv
module gpx_bus_fsm
    import gpx_pkg::*;
#(
    parameter logic [4:0] ADDR_FIXED = 5'b11100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              addr_strap,
    input  logic                    sda_lvl,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_det,
    input  logic                    stop_det,
    input  logic [BYTE_W-1:0]       rd_data,
    output logic [PTR_W-1:0]        ptr,
    output logic                    wr_en,
    output logic [BYTE_W-1:0]       wr_data,
    output logic                    rd_strobe,
    output logic                    sda_oe,
    output gpx_state_e              st
);
    localparam logic [3:0] BITS_IN  = 4'd8;
    localparam logic [3:0] LAST_OUT = 4'd7;

    gpx_state_e        nxt;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic              nack_q;
    logic              addr_hit;
    logic              byte_in_done;
    logic              bus_event;

    assign addr_hit     = (rx_q[7:1] == {ADDR_FIXED, addr_strap});
    assign byte_in_done = scl_fall && (cnt == BITS_IN);
    assign bus_event    = start_det | stop_det;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_in_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rx_q[0] ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_in_done) nxt = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_in_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && cnt == LAST_OUT) nxt = ST_RACK;
                ST_RACK:      if (scl_fall) nxt = nack_q ? ST_IDLE : ST_RDATA;
            endcase
        end
    end

    // datapath: bit counter, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            nack_q <= 1'b0;
            ptr    <= IDX_LEVEL;
        end else if (bus_event) begin
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: cnt <= '0;
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_q <= {rx_q[BYTE_W-2:0], sda_lvl};
                        cnt  <= cnt + 4'd1;
                    end
                    if (st == ST_CMD && byte_in_done) ptr <= rx_q[PTR_W-1:0];
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rx_q[0]) tx_q <= rd_data;
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: if (scl_fall) cnt <= '0;
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                        cnt  <= cnt + 4'd1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) nack_q <= sda_lvl;
                    if (scl_fall) begin
                        cnt  <= '0;
                        tx_q <= rd_data;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        wr_en     = 1'b0;
        rd_strobe = 1'b0;
        wr_data   = rx_q;
        unique case (st)
            ST_IDLE, ST_ADDR, ST_CMD: sda_oe = 1'b0;
            ST_ADDR_ACK: begin
                sda_oe    = 1'b1;
                rd_strobe = scl_fall & rx_q[0] & ~bus_event;
            end
            ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_WDATA:  wr_en = byte_in_done & ~bus_event;
            ST_RDATA:  sda_oe = ~tx_q[BYTE_W-1];
            ST_RACK:   rd_strobe = scl_fall & ~nack_q & ~bus_event;
        endcase
    end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int PIN_SYNC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BYTE_W-1:0]    pin_in,
    input  logic                 wr_en,
    input  logic [PTR_W-1:0]     ptr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 rd_strobe,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [BYTE_W-1:0]    pin_out,
    output logic [BYTE_W-1:0]    pin_oe,
    output logic                 irq_pull
);
    localparam int WARM   = PIN_SYNC + 1;
    localparam int WARM_W = $clog2(WARM + 1);
    localparam logic [WARM_W-1:0] WARM_END = WARM_W'(WARM);

    logic [PIN_SYNC-1:0][BYTE_W-1:0] pin_pipe;
    logic [BYTE_W-1:0] drive_q;
    logic [BYTE_W-1:0] inv_q;
    logic [BYTE_W-1:0] dir_q;
    logic [BYTE_W-1:0] snap_q;
    logic [BYTE_W-1:0] level;
    logic [WARM_W-1:0] warm_q;
    logic              warm_done;
    logic              irq_q;

    assign level     = pin_pipe[PIN_SYNC-1] ^ inv_q;
    assign warm_done = (warm_q == WARM_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_pipe <= '0;
            drive_q  <= '1;
            inv_q    <= '0;
            dir_q    <= '1;
            snap_q   <= '0;
            warm_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            pin_pipe[0] <= pin_in;
            for (int i = 1; i < PIN_SYNC; i++) pin_pipe[i] <= pin_pipe[i-1];
            if (!warm_done) begin
                warm_q <= warm_q + 1'b1;
                snap_q <= level;
            end else if (rd_strobe && ptr == IDX_LEVEL) begin
                snap_q <= level;
            end
            if (wr_en) begin
                unique case (ptr)
                    IDX_LEVEL: ;
                    IDX_DRIVE: drive_q <= wr_data;
                    IDX_INV:   inv_q   <= wr_data;
                    IDX_DIR:   dir_q   <= wr_data;
                endcase
            end
            irq_q <= warm_done && (|((level ^ snap_q) & dir_q));
        end
    end

    always_comb begin
        unique case (ptr)
            IDX_LEVEL: rd_data = level;
            IDX_DRIVE: rd_data = drive_q;
            IDX_INV:   rd_data = inv_q;
            IDX_DIR:   rd_data = dir_q;
        endcase
    end

    assign pin_out  = drive_q;
    assign pin_oe   = ~dir_q;
    assign irq_pull = irq_q;
endmodule

// File: rtl/gpx_top.sv
module gpx_top
    import gpx_pkg::*;
#(
    parameter int         LINE_SYNC  = 2,
    parameter int         PIN_SYNC   = 2,
    parameter logic [4:0] ADDR_FIXED = 5'b11100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic [1:0]  addr_strap,
    input  logic [7:0]  pin_in,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_oe,
    output logic        irq_pull
);
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic              rd_strobe;
    logic [BYTE_W-1:0] rd_data;
    gpx_state_e        st;

    gpx_line_sync #(.STAGES(LINE_SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    gpx_bus_fsm #(.ADDR_FIXED(ADDR_FIXED)) u_fsm (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
        .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .sda_oe(sda_oe), .st(st)
    );

    gpx_regs #(.PIN_SYNC(PIN_SYNC)) u_regs (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .ptr(ptr), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_pull(irq_pull)
    );
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic [7:0] pin_out,
    input logic [7:0] pin_oe,
    input logic       irq_pull,
    input logic       start_det,
    input logic       stop_det,
    input logic       wr_en,
    input logic [1:0] ptr,
    input gpx_state_e st
);
    // R7: a cycle held in reset leaves defaults on the pins
    a_r7_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> (pin_out == 8'hFF && pin_oe == 8'h00 && !irq_pull && !sda_oe));

    // R11: START restarts the address phase, STOP idles the engine
    a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> st == ST_ADDR);
    a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (st == ST_IDLE && !sda_oe));

    // R6: a write aimed at the pin-level index leaves the pins alone
    a_r6_level_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == IDX_LEVEL) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R10: every accepted data byte is followed by an acknowledge drive
    a_r10_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe);

    // R10: SDA is released while the controller acknowledges a read byte
    a_r10_release_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_RACK |-> !sda_oe);
endmodule

bind gpx_top gpx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_pull(irq_pull), .start_det(start_det),
    .stop_det(stop_det), .wr_en(wr_en), .ptr(ptr), .st(st)
);

// File: tb/sim_gpx_top.sv
`timescale 1ns/1ps
module sim_gpx_top;
    localparam int Q = 8;
    localparam logic [7:0] W_ADDR = 8'hE4;
    localparam logic [7:0] R_ADDR = 8'hE5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [1:0] addr_strap = 2'b10;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq_pull;
    logic       sda_line;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    gpx_top u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .addr_strap(addr_strap), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pull(irq_pull)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b1; cyc(Q);
    endtask

    task automatic bit_clk(input bit v, output bit s);
        cyc(Q);
        sda_m = v; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        s = sda_line; cyc(Q);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit nack);
        bit s;
        for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
        bit_clk(1'b1, nack);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, s);
            b[i] = s;
        end
        bit_clk(~give_ack, s);
        sda_m = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] cmd, input logic [7:0] d);
        bit n;
        i2c_start();
        send_byte(W_ADDR, n); chk(!n, "R1 addr ack", {7'd0, n}, 8'h00);
        send_byte(cmd, n);    chk(!n, "R10 cmd ack", {7'd0, n}, 8'h00);
        send_byte(d, n);      chk(!n, "R10 data ack", {7'd0, n}, 8'h00);
        i2c_stop();
        cyc(4);
    endtask

    task automatic reg_read(input logic [7:0] cmd, output logic [7:0] d);
        bit n;
        i2c_start();
        send_byte(W_ADDR, n);
        send_byte(cmd, n);
        i2c_start();
        send_byte(R_ADDR, n);
        recv_byte(1'b0, d);
        i2c_stop();
        cyc(4);
    endtask

    task automatic t_reset();
        chk(pin_out == 8'hFF, "R7 reset drive", pin_out, 8'hFF);
        chk(pin_oe == 8'h00, "R7 reset dir", pin_oe, 8'h00);
        chk(!irq_pull && !sda_oe, "R7 reset irq/sda", {6'd0, irq_pull, sda_oe}, 8'h00);
    endtask

    task automatic t_address();
        bit n;
        i2c_start();
        send_byte(8'hE2, n);
        chk(n, "R1 wrong addr nack", {7'd0, n}, 8'h01);
        send_byte(8'h01, n);
        send_byte(8'h00, n);
        i2c_stop(); cyc(4);
        chk(pin_out == 8'hFF, "R1 foreign write ignored", pin_out, 8'hFF);
        i2c_start();
        send_byte(W_ADDR, n); chk(!n, "R1 own addr ack", {7'd0, n}, 8'h00);
        send_byte(8'h01, n);  chk(!n, "R10 cmd ack", {7'd0, n}, 8'h00);
        send_byte(8'h5A, n);  chk(!n, "R10 data ack", {7'd0, n}, 8'h00);
        i2c_stop(); cyc(4);
        chk(pin_out == 8'h5A, "R4 drive value", pin_out, 8'h5A);
    endtask

    task automatic t_rw_regs();
        logic [7:0] d;
        reg_write(8'h03, 8'hF0);
        chk(pin_oe == 8'h0F, "R4 drive enables", pin_oe, 8'h0F);
        reg_read(8'h03, d); chk(d == 8'hF0, "R2 read dir", d, 8'hF0);
        reg_read(8'h01, d); chk(d == 8'h5A, "R2 read drive", d, 8'h5A);
    endtask

    task automatic t_level();
        logic [7:0] d;
        pin_in = 8'h3C;
        reg_write(8'h02, 8'h0F);
        reg_read(8'h00, d); chk(d == 8'h33, "R5 level xor inversion", d, 8'h33);
        reg_read(8'h02, d); chk(d == 8'h0F, "R2 read inversion", d, 8'h0F);
    endtask

    task automatic t_level_write();
        logic [7:0] d;
        reg_write(8'h00, 8'h00);
        chk(pin_out == 8'h5A, "R6 drive unchanged", pin_out, 8'h5A);
        chk(pin_oe == 8'h0F, "R6 dir unchanged", pin_oe, 8'h0F);
        reg_read(8'h02, d); chk(d == 8'h0F, "R6 inversion unchanged", d, 8'h0F);
    endtask

    task automatic t_pointer();
        logic [7:0] d0, d1;
        bit n;
        i2c_start();
        send_byte(R_ADDR, n);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        i2c_stop(); cyc(4);
        chk(d0 == 8'h0F, "R3 pointer kept", d0, 8'h0F);
        chk(d1 == 8'h0F, "R3 second read same reg", d1, 8'h0F);
        i2c_start();
        send_byte(W_ADDR, n);
        send_byte(8'h01, n);
        send_byte(8'h11, n);
        send_byte(8'h22, n);
        i2c_stop(); cyc(4);
        chk(pin_out == 8'h22, "R3 burst write same reg", pin_out, 8'h22);
        reg_write(8'hFD, 8'h77);
        chk(pin_out == 8'h77, "R2 upper cmd bits ignored", pin_out, 8'h77);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        reg_write(8'h02, 8'h00);
        reg_write(8'h03, 8'hFF);
        pin_in = 8'h00; cyc(6);
        reg_read(8'h00, d);
        chk(d == 8'h00 && !irq_pull, "R9 quiet after read", {7'd0, irq_pull}, 8'h00);
        pin_in = 8'h01; cyc(10);
        chk(irq_pull, "R8 input change raises", {7'd0, irq_pull}, 8'h01);
        pin_in = 8'h00; cyc(10);
        chk(!irq_pull, "R9 return releases", {7'd0, irq_pull}, 8'h00);
        pin_in = 8'h04; cyc(10);
        chk(irq_pull, "R8 second change raises", {7'd0, irq_pull}, 8'h01);
        reg_read(8'h00, d);
        chk(d == 8'h04, "R5 level read", d, 8'h04);
        chk(!irq_pull, "R9 read releases", {7'd0, irq_pull}, 8'h00);
        reg_write(8'h03, 8'hFB);
        pin_in = 8'h00; cyc(10);
        chk(!irq_pull, "R8 output pin ignored", {7'd0, irq_pull}, 8'h00);
    endtask

    task automatic t_nack_restart();
        logic [7:0] d;
        bit n;
        i2c_start();
        send_byte(R_ADDR, n);
        recv_byte(1'b0, d);
        cyc(2 * Q);
        chk(!sda_oe, "R10 released after nack", {7'd0, sda_oe}, 8'h00);
        chk(d == 8'hFB, "R3 read after nack path", d, 8'hFB);
        i2c_stop(); cyc(4);
        i2c_start();
        send_byte(W_ADDR, n);
        send_byte(8'h01, n);
        i2c_start();
        send_byte(R_ADDR, n);
        chk(!n, "R11 repeated start ack", {7'd0, n}, 8'h00);
        recv_byte(1'b0, d);
        i2c_stop(); cyc(4);
        chk(d == 8'h77, "R11 read after restart", d, 8'h77);
        chk(!sda_oe, "R11 stop releases", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_reset_mid();
        logic [7:0] d;
        reg_write(8'h03, 8'h00);
        chk(pin_oe == 8'hFF, "R4 all driven", pin_oe, 8'hFF);
        rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(8);
        chk(pin_oe == 8'h00 && pin_out == 8'hFF, "R7 reset restores", pin_oe, 8'h00);
        reg_read(8'h02, d);
        chk(d == 8'h00, "R7 inversion default", d, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(8);
        t_reset();
        t_address();
        t_rw_regs();
        t_level();
        t_level_write();
        t_pointer();
        t_irq();
        t_nack_restart();
        t_reset_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule